// File: doc/BRIEF.md
# Burst-Beat and Row-Address Shuffler for a Multi-Chip Memory Channel

This block sits on a memory controller's data path, between the error-correction encoder and decoder and a 64-bit channel built from eight chips, each with an 8-bit data lane. Some bit positions inside a burst, and some rows inside each 512-row group of an array, fail far more often than others when the array is run with tight timing. Without shuffling, those weak spots from all eight chips can land in the same beat and the same codeword. The shuffler spreads them out.

On the write path it collects a burst of eight 64-bit beats and sends it out rotated lane by lane. Chip c's lane is rotated by c beat positions, so one weak beat position in every chip ends up in eight different outgoing beats. The read path applies the exact inverse rotation, so a burst written and read back returns unchanged. Each chip also receives its own copy of the row address. The low nine bits of that copy are XORed with a per-chip key equal to (c × stride) mod 512, where the stride is a configuration input. The upper row bits are left alone, so a row never leaves its 512-row group. A bypass input turns off both the data rotation and the row mapping.

Top module: `shuffler_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, every valid output is low and every data and row output is zero.
- R2: Beats carry lane c in bits [8c+7:8c]. In a burst that is not bypassed, lane c of the outgoing channel beat b equals lane c of the incoming write beat (b + c) mod 8.
- R3: On the read path, lane c of restored beat b equals lane c of the channel beat (b − c) mod 8. A burst looped from the write output into the read input comes back identical to the original write beats.
- R4: The first shuffled beat is valid on the cycle after the eighth input beat of a burst is accepted. The eight beats then follow on consecutive cycles in beat order, and bursts that arrive back to back produce an unbroken output stream.
- R5: Input beats of a burst may arrive with idle cycles between them. Idle cycles do not advance the burst, and data presented with valid low has no effect on any output.
- R6: When the bypass input is high on the cycle the eighth beat is accepted, that burst passes through in its original order on either path. The bypass level during the earlier beats has no effect.
- R7: One cycle after a row request, chip c's row has the input's upper bits unchanged, and its low nine bits equal the input's low nine bits XOR ((c × stride) mod 512).
- R8: When bypass is high during a row request, every chip receives the input row unchanged.
- R9: For a fixed stride, each chip's mapping sends the 512 rows of a group to 512 distinct rows of that group. When the stride is odd, the eight chips receive eight distinct rows for any single request.
- R10: Whenever a valid output is low, its data or row output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bypass | input | 1 | Pass beats and rows through unchanged |
| cfg_row_stride | input | 9 | Multiplier that forms the per-chip row key |
| wr_valid | input | 1 | Write beat from the encoder is valid |
| wr_data | input | 64 | Write beat from the encoder |
| ch_wr_valid | output | 1 | Shuffled write beat to the channel is valid |
| ch_wr_data | output | 64 | Shuffled write beat to the channel |
| ch_rd_valid | input | 1 | Read beat from the channel is valid |
| ch_rd_data | input | 64 | Read beat from the channel |
| rd_valid | output | 1 | Restored read beat to the decoder is valid |
| rd_data | output | 64 | Restored read beat to the decoder |
| row_valid | input | 1 | Row request is valid |
| row_addr | input | 16 | Requested row address |
| chip_row_valid | output | 1 | Per-chip rows are valid |
| chip_row | output | 128 | Row for chip c in bits [16c+15:16c] |

## Verification
Both beat paths release the first beat of a burst one register stage after the eighth input beat is taken, and the per-chip rows appear one register stage after the request. The bench drives inputs on the falling edge. A reference model of the burst collector checks the beat paths one time unit after that falling edge, so each sample sees the outputs of the edge just passed and the inputs for the next one. Row results are checked one full cycle after the request is driven. Every row-group offset is swept for several strides and for bypass.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
    localparam int CHIPS  = 8;
    localparam int LANE_W = 8;
    localparam int BEATS  = 8;
    localparam int ROW_W  = 16;
    localparam int GRP_W  = 9;
    localparam int BUS_W  = CHIPS * LANE_W;
    localparam int BIW    = $clog2(BEATS);

    typedef enum logic { DIR_WRITE = 1'b0, DIR_READ = 1'b1 } dir_e;

    typedef logic [LANE_W-1:0] lane_t;
    typedef lane_t [CHIPS-1:0] beat_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef row_t [CHIPS-1:0]  row_vec_t;

    // Beat position that lane c of output beat b is taken from.
    function automatic int src_beat(dir_e d, int b, int c);
        int r;
        r = c % BEATS;
        if (d == DIR_WRITE) return (b + r) % BEATS;
        return (b + BEATS - r) % BEATS;
    endfunction

    // Per-chip XOR key inside one row group.
    function automatic logic [GRP_W-1:0] row_key(int c, logic [GRP_W-1:0] stride);
        return GRP_W'(c) * stride;
    endfunction
endpackage

// File: rtl/beat_permuter.sv
module beat_permuter
    import shuf_pkg::*;
#(
    parameter dir_e DIR = DIR_WRITE
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  bypass,
    input  logic  in_valid,
    input  beat_t in_beat,
    output logic  out_valid,
    output beat_t out_beat
);
    localparam logic [BIW-1:0] LAST = BIW'(BEATS - 1);

    beat_t cap      [BEATS];
    beat_t hold     [BEATS];
    beat_t whole    [BEATS];
    beat_t shuffled [BEATS];
    logic [BIW-1:0] cnt;
    logic [BIW-1:0] ecnt;
    logic           emitting;
    logic           load;

    assign load = in_valid && (cnt == LAST);

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        if (b == BEATS - 1) begin : g_live
            assign whole[b] = in_beat;
        end else begin : g_stored
            assign whole[b] = cap[b];
        end
        for (genvar c = 0; c < CHIPS; c++) begin : g_lane
            localparam int SRC = src_beat(DIR, b, c);
            assign shuffled[b][c] = bypass ? whole[b][c] : whole[SRC][c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            ecnt     <= '0;
            emitting <= 1'b0;
        end else begin
            if (in_valid) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (load) begin
                ecnt     <= '0;
                emitting <= 1'b1;
            end else if (emitting) begin
                ecnt <= ecnt + 1'b1;
                if (ecnt == LAST) emitting <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) cap[cnt] <= in_beat;
        if (load) begin
            for (int b = 0; b < BEATS; b++) hold[b] <= shuffled[b];
        end
    end

    assign out_valid = emitting;
    assign out_beat  = emitting ? hold[ecnt] : '0;

    // R4
    load_then_valid_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> out_valid);
    // R4
    burst_run_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ecnt != LAST) |=> out_valid);
    // R4
    start_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid));
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(cnt));
endmodule

// File: rtl/row_scrambler.sv
module row_scrambler
    import shuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bypass,
    input  logic [GRP_W-1:0] stride,
    input  logic             in_valid,
    input  row_t             in_row,
    output logic             out_valid,
    output row_vec_t         out_rows
);
    row_vec_t mapped;
    row_vec_t held;
    logic     vld;

    for (genvar c = 0; c < CHIPS; c++) begin : g_chip
        assign mapped[c] = bypass ? in_row
                         : {in_row[ROW_W-1:GRP_W], in_row[GRP_W-1:0] ^ row_key(c, stride)};

        // R7
        upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_rows[c][ROW_W-1:GRP_W] == $past(in_row[ROW_W-1:GRP_W]));
        // R8
        bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && bypass) |=> out_rows[c] == $past(in_row));
    end

    always_ff @(posedge clk) begin
        if (rst) vld <= 1'b0;
        else     vld <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (in_valid) held <= mapped;
    end

    assign out_valid = vld;
    assign out_rows  = vld ? held : '0;

    // R7
    row_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R10
    row_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && out_rows == '0));
endmodule

// File: rtl/shuffler_top.sv
module shuffler_top
    import shuf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_bypass,
    input  logic [GRP_W-1:0]       cfg_row_stride,
    input  logic                   wr_valid,
    input  logic [BUS_W-1:0]       wr_data,
    output logic                   ch_wr_valid,
    output logic [BUS_W-1:0]       ch_wr_data,
    input  logic                   ch_rd_valid,
    input  logic [BUS_W-1:0]       ch_rd_data,
    output logic                   rd_valid,
    output logic [BUS_W-1:0]       rd_data,
    input  logic                   row_valid,
    input  logic [ROW_W-1:0]       row_addr,
    output logic                   chip_row_valid,
    output logic [CHIPS*ROW_W-1:0] chip_row
);
    beat_t    wr_in, wr_out, rd_in, rd_out;
    row_vec_t rows;

    assign wr_in = wr_data;
    assign rd_in = ch_rd_data;

    beat_permuter #(.DIR(DIR_WRITE)) u_wr (
        .clk(clk), .rst(rst), .bypass(cfg_bypass),
        .in_valid(wr_valid), .in_beat(wr_in),
        .out_valid(ch_wr_valid), .out_beat(wr_out)
    );

    beat_permuter #(.DIR(DIR_READ)) u_rd (
        .clk(clk), .rst(rst), .bypass(cfg_bypass),
        .in_valid(ch_rd_valid), .in_beat(rd_in),
        .out_valid(rd_valid), .out_beat(rd_out)
    );

    row_scrambler u_row (
        .clk(clk), .rst(rst), .bypass(cfg_bypass), .stride(cfg_row_stride),
        .in_valid(row_valid), .in_row(row_addr),
        .out_valid(chip_row_valid), .out_rows(rows)
    );

    assign ch_wr_data = wr_out;
    assign rd_data    = rd_out;
    assign chip_row   = rows;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!ch_wr_valid && !rd_valid && !chip_row_valid));
    // R10
    beat_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ch_wr_valid |-> ch_wr_data == '0) and (!rd_valid |-> rd_data == '0));
endmodule

// File: tb/tb_shuffler_top.sv
`timescale 1ns/1ps
module tb_shuffler_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst = 1'b1;
    logic         cfg_bypass = 1'b0;
    logic [8:0]   cfg_row_stride = 9'd1;
    logic         wr_valid = 1'b0;
    logic [63:0]  wr_data = '0;
    logic         ch_wr_valid;
    logic [63:0]  ch_wr_data;
    logic         ch_rd_valid = 1'b0;
    logic [63:0]  ch_rd_data = '0;
    logic         rd_valid;
    logic [63:0]  rd_data;
    logic         row_valid = 1'b0;
    logic [15:0]  row_addr = '0;
    logic         chip_row_valid;
    logic [127:0] chip_row;

    shuffler_top dut (
        .clk(clk), .rst(rst), .cfg_bypass(cfg_bypass), .cfg_row_stride(cfg_row_stride),
        .wr_valid(wr_valid), .wr_data(wr_data), .ch_wr_valid(ch_wr_valid), .ch_wr_data(ch_wr_data),
        .ch_rd_valid(ch_rd_valid), .ch_rd_data(ch_rd_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .row_valid(row_valid), .row_addr(row_addr), .chip_row_valid(chip_row_valid), .chip_row(chip_row)
    );

    int nvec = 0;
    int nfail = 0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference: lane c of output beat b, per the rotation rules of R2, R3, R6.
    function automatic logic [63:0] ref_beat(int p, logic [63:0] src [8], bit byp, int b);
        logic [63:0] r;
        for (int c = 0; c < 8; c++) begin
            int s;
            if (byp)         s = b;
            else if (p == 0) s = (b + c) % 8;
            else             s = ((b - c) % 8 + 8) % 8;
            r[8*c +: 8] = src[s][8*c +: 8];
        end
        return r;
    endfunction

    // Burst model for both paths (0 = write, 1 = read).
    logic [63:0] mb [2][8];
    logic [63:0] mh [2][8];
    int          mc [2];
    int          mi [2];
    bit          me [2];
    string       mtag [2];
    string       ptag [2];
    bit          rt_mode = 1'b0;
    logic [63:0] rt_src [$];
    logic [63:0] ov_d [2];
    bit          ov_v [2];
    logic [63:0] iv_d [2];
    bit          iv_v [2];

    always begin
        @(negedge clk);
        #1;
        if (rst) begin
            for (int p = 0; p < 2; p++) begin
                mc[p] = 0; mi[p] = 0; me[p] = 1'b0;
            end
        end else begin
            ov_v[0] = ch_wr_valid; ov_d[0] = ch_wr_data;
            ov_v[1] = rd_valid;    ov_d[1] = rd_data;
            iv_v[0] = wr_valid;    iv_d[0] = wr_data;
            iv_v[1] = ch_rd_valid; iv_d[1] = ch_rd_data;
            for (int p = 0; p < 2; p++) begin
                chk(ov_v[p] == me[p], "R4", p == 0 ? "write valid" : "read valid",
                    64'(ov_v[p]), 64'(me[p]));
                if (ov_v[p] && me[p])
                    chk(ov_d[p] == mh[p][mi[p]], mtag[p], "beat data", ov_d[p], mh[p][mi[p]]);
                if (!ov_v[p])
                    chk(ov_d[p] == '0, "R10", "idle beat data", ov_d[p], 64'd0);
            end
            if (rt_mode && rd_valid) begin
                logic [63:0] e;
                e = rt_src.pop_front();
                chk(rd_data == e, "R3", "round trip", rd_data, e);
            end
            for (int p = 0; p < 2; p++) begin
                if (me[p]) begin
                    if (mi[p] == 7) me[p] = 1'b0;
                    else            mi[p]++;
                end
                if (iv_v[p]) begin
                    mb[p][mc[p]] = iv_d[p];
                    if (mc[p] == 7) begin
                        for (int b = 0; b < 8; b++) mh[p][b] = ref_beat(p, mb[p], cfg_bypass, b);
                        me[p] = 1'b1; mi[p] = 0; mtag[p] = ptag[p]; mc[p] = 0;
                    end else begin
                        mc[p]++;
                    end
                end
            end
        end
    end

    task automatic idle(int p);
        if (p == 0) begin wr_valid = 1'b0; wr_data = {$urandom, $urandom}; end
        else        begin ch_rd_valid = 1'b0; ch_rd_data = {$urandom, $urandom}; end
        @(negedge clk);
    endtask

    task automatic burst(int p, bit gaps, bit byp_early, bit byp_last);
        for (int i = 0; i < 8; i++) begin
            if (gaps) repeat ($urandom % 3) idle(p);
            cfg_bypass = (i == 7) ? byp_last : byp_early;
            if (p == 0) begin wr_valid = 1'b1; wr_data = {$urandom, $urandom}; end
            else        begin ch_rd_valid = 1'b1; ch_rd_data = {$urandom, $urandom}; end
            @(negedge clk);
        end
        if (p == 0) wr_valid = 1'b0; else ch_rd_valid = 1'b0;
    endtask

    task automatic row_sweep(logic [8:0] stride, bit byp, int count);
        bit seen [8][512];
        cfg_row_stride = stride;
        cfg_bypass = byp;
        for (int c = 0; c < 8; c++) for (int v = 0; v < 512; v++) seen[c][v] = 1'b0;
        for (int v = 0; v < count; v++) begin
            logic [15:0] a;
            a = {7'($urandom), 9'(v)};
            row_valid = 1'b1; row_addr = a;
            @(negedge clk);
            row_valid = 1'b0; row_addr = 16'($urandom);
            chk(chip_row_valid, "R7", "row valid", 64'(chip_row_valid), 64'd1);
            for (int c = 0; c < 8; c++) begin
                logic [15:0] e, g;
                g = chip_row[16*c +: 16];
                e = byp ? a : {a[15:9], a[8:0] ^ 9'((c * int'(stride)) % 512)};
                chk(g == e, byp ? "R8" : "R7", "chip row", 64'(g), 64'(e));
                seen[c][g[8:0]] = 1'b1;
                if (!byp && stride[0])
                    for (int d = 0; d < c; d++)
                        chk(g != chip_row[16*d +: 16], "R9", "distinct chip rows", 64'(g),
                            64'(chip_row[16*d +: 16]));
            end
            @(negedge clk);
            chk(!chip_row_valid && chip_row == '0, "R10", "idle rows", chip_row[63:0], 64'd0);
        end
        if (count == 512 && !byp)
            for (int c = 0; c < 8; c++) begin
                int n;
                n = 0;
                for (int v = 0; v < 512; v++) n += seen[c][v];
                chk(n == 512, "R9", "rows covered per chip", 64'(n), 64'd512);
            end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        @(negedge clk);
        wr_valid = 1'b1; ch_rd_valid = 1'b1; row_valid = 1'b1;
        wr_data = '1; ch_rd_data = '1; row_addr = '1;
        repeat (9) begin
            @(negedge clk);
            chk(!ch_wr_valid && ch_wr_data == '0, "R1", "write out in reset", ch_wr_data, 64'd0);
            chk(!rd_valid && rd_data == '0, "R1", "read out in reset", rd_data, 64'd0);
            chk(!chip_row_valid && chip_row == '0, "R1", "rows in reset", chip_row[63:0], 64'd0);
        end
        wr_valid = 1'b0; ch_rd_valid = 1'b0; row_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk(!ch_wr_valid && !rd_valid && !chip_row_valid, "R1", "first cycle after reset",
            {61'd0, ch_wr_valid, rd_valid, chip_row_valid}, 64'd0);

        ptag[0] = "R2"; ptag[1] = "R3";
        repeat (6) burst(0, 1'b0, 1'b0, 1'b0);
        repeat (6) burst(1, 1'b0, 1'b0, 1'b0);
        repeat (12) idle(0);
        ptag[0] = "R5"; ptag[1] = "R5";
        repeat (6) burst(0, 1'b1, 1'b0, 1'b0);
        repeat (6) burst(1, 1'b1, 1'b0, 1'b0);
        repeat (12) idle(1);
        ptag[0] = "R6"; ptag[1] = "R6";
        repeat (3) burst(0, 1'b0, 1'b1, 1'b1);
        repeat (3) burst(1, 1'b1, 1'b1, 1'b1);
        burst(0, 1'b0, 1'b1, 1'b0);
        burst(1, 1'b0, 1'b0, 1'b1);
        burst(0, 1'b1, 1'b0, 1'b1);
        burst(1, 1'b0, 1'b1, 1'b0);
        cfg_bypass = 1'b0;
        repeat (12) idle(0);

        ptag[0] = "R2"; ptag[1] = "R3";
        rt_mode = 1'b1;
        for (int k = 0; k < 64; k++) begin
            wr_valid = (k < 32);
            wr_data = {$urandom, $urandom};
            if (wr_valid) rt_src.push_back(wr_data);
            ch_rd_valid = ch_wr_valid;
            ch_rd_data = ch_wr_data;
            @(negedge clk);
        end
        ch_rd_valid = 1'b0;
        rt_mode = 1'b0;
        chk(rt_src.size() == 0, "R3", "round trip beats left", 64'(rt_src.size()), 64'd0);
        repeat (4) @(negedge clk);

        row_sweep(9'd1, 1'b0, 512);
        row_sweep(9'h0AB, 1'b0, 512);
        row_sweep(9'h1FF, 1'b0, 512);
        row_sweep(9'h002, 1'b0, 512);
        row_sweep(9'h0AB, 1'b1, 64);
        cfg_bypass = 1'b0;

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule